// File: doc/BRIEF.md
# Reset Pad State Sequencer

This block sets the data value and output enable of every pad in a bank while the device goes into reset and comes out of it. Each pad has a reset-release group, set by a 4-bit code in a parameter vector. The group decides when the pad stops floating and what it drives next. Some pads release when the global reset sources clear. Others wait for the reset-out signal to rise. The rest stay floating until their peripheral is enabled, and from then on they pass the peripheral's data and enable through to the pad.

One group drives a clock on the pad. That clock toggles on every cycle, but it is held low for a fixed window just before reset-out is released. Pads can also be marked as general-purpose I/O, and these behave as floating-until-enabled pads whatever their group code says. Pads in a default power-down set stay floating until their power-down bit is clear and their pin-select bit picks them. All pins are plain control and data levels. There is no streaming interface, so the block has no valid/ready handshake and no back-pressure.

Top module: `pad_reset_seq`

## Requirements
- R1: Global reset is active when any of `rst_por`, `rst_ext` or `rst_max` is high. While it is active, every pad of code 0, 1, 2, 3, 6 or 7, and every general-purpose pad, has `pad_oe`=0. Any pad with `pad_oe`=0 shows `pad_do`=0.
- R2: Pads of code 0 and code 1 float (`pad_oe`=0) unless `resetout_n`=1 and global reset is inactive. When released, they drive a constant 0 (code 0) or 1 (code 1) with `pad_oe`=1, whatever `per_en` is.
- R3: Pads of code 2 float until released in the sense of R2. While released with `per_en`=0, they have `pad_oe`=1 and drive a fixed alternating bit equal to the pad index modulo 2. While released with `per_en`=1, `pad_oe`=`per_oe` and `pad_do`=`per_do`&`per_oe`.
- R4: Pads of code 3 float unless released and `per_en`=1. When released and enabled, they follow the peripheral as in R3.
- R5: Pads of code 4 and code 5 drive a constant 0 or 1 with `pad_oe`=1, through reset and after it. This holds until they are released and `per_en`=1, and then they follow the peripheral.
- R6: Pads of code 6 and code 7 float only while global reset is active. As soon as it is inactive, they drive 0 or 1 with `pad_oe`=1, whatever the level of `resetout_n`.
- R7: A pad of code 8 has `pad_oe`=1 at all times. Its data is 0 during global reset, and it inverts on every rising clock edge outside the pause window.
- R8: Number the rising edges after global reset clears as 1, 2, and so on. After edges PAUSE_LEAD+1 through PAUSE_LEAD+PAUSE_CYCLES, the clock pad reads 0. After edge n ≤ PAUSE_LEAD it reads n mod 2. After edge PAUSE_LEAD+PAUSE_CYCLES+k it reads k mod 2.
- R9: A pad whose bit is set in GPIO_MASK behaves exactly as a code-3 pad, whatever its group code.
- R10: A pad whose bit is set in PD_MASK floats unless its `pd_reg` bit is 0 and its `mux_sel` bit is 1. When both conditions hold, it follows its group behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_por | input | 1 | Power-on reset source, active high |
| rst_ext | input | 1 | External reset source, active high |
| rst_max | input | 1 | Maximum reset source, active high |
| resetout_n | input | 1 | Reset-out, low while asserted |
| per_en | input | NUM_PADS | Per-pad peripheral enabled flag |
| per_do | input | NUM_PADS | Per-pad peripheral output data |
| per_oe | input | NUM_PADS | Per-pad peripheral output enable |
| pd_reg | input | NUM_PADS | Per-pad power-down register bit (1 = powered down) |
| mux_sel | input | NUM_PADS | Per-pad pin-select bit (1 = function selected) |
| pad_do | output | NUM_PADS | Pad drive value |
| pad_oe | output | NUM_PADS | Pad output enable (0 = tristate) |

## Verification
The hardest state to reach from the ports is the clock pause window. It only exists at a fixed cycle offset after the reset sources clear, and only the free-running toggle shows it. The bench releases the power-on source at a falling edge and then counts rising edges one by one. At each edge it compares the clock pad against an arithmetic prediction across the lead-in, the pause and the resumed toggling. The static group rules are covered by a sweep over every reset phase and sixteen peripheral, power-down and pin-select patterns.

// File: rtl/pad_rst_pkg.sv
package pad_rst_pkg;

  typedef enum logic [3:0] {
    GRP_ZL_LATE  = 4'd0,
    GRP_ZH_LATE  = 4'd1,
    GRP_ZX_LATE  = 4'd2,
    GRP_Z        = 4'd3,
    GRP_LOW      = 4'd4,
    GRP_HIGH     = 4'd5,
    GRP_ZL_EARLY = 4'd6,
    GRP_ZH_EARLY = 4'd7,
    GRP_CLK      = 4'd8
  } pad_grp_e;

  typedef struct packed {
    logic dout;
    logic oe;
  } pad_drv_t;

  localparam pad_drv_t DRV_OFF = '{dout: 1'b0, oe: 1'b0};

  function automatic pad_drv_t drv_const(input logic v);
    return '{dout: v, oe: 1'b1};
  endfunction

  function automatic pad_drv_t drv_follow(input logic d, input logic e);
    return '{dout: d & e, oe: e};
  endfunction

endpackage

// File: rtl/rst_phase_gen.sv
module rst_phase_gen
#(
  parameter int PAUSE_LEAD   = 4,
  parameter int PAUSE_CYCLES = 8
)
(
  input  logic clk,
  input  logic rst_por,
  input  logic rst_ext,
  input  logic rst_max,
  output logic glob_rst,
  output logic ck_tgl
);

  localparam int LIMIT = PAUSE_LEAD + PAUSE_CYCLES;
  localparam int CW    = $clog2(LIMIT + 2);

  logic [CW-1:0] since_rel;
  logic          in_pause;

  assign glob_rst = rst_por | rst_ext | rst_max;
  assign in_pause = (since_rel >= CW'(PAUSE_LEAD)) && (since_rel < CW'(LIMIT));

  always_ff @(posedge clk or posedge glob_rst) begin
    if (glob_rst) begin
      since_rel <= '0;
    end else if (since_rel < CW'(LIMIT)) begin
      since_rel <= since_rel + CW'(1);
    end
  end

  always_ff @(posedge clk or posedge glob_rst) begin
    if (glob_rst) begin
      ck_tgl <= 1'b0;
    end else if (in_pause) begin
      ck_tgl <= 1'b0;
    end else begin
      ck_tgl <= ~ck_tgl;
    end
  end

endmodule

// File: rtl/pad_lane.sv
module pad_lane
  import pad_rst_pkg::*;
#(
  parameter pad_grp_e GRP = GRP_Z,
  parameter bit       ALT = 1'b0
)
(
  input  logic     glob_rst,
  input  logic     resetout_n,
  input  logic     en,
  input  logic     pdo,
  input  logic     poe,
  input  logic     ck_tgl,
  output pad_drv_t drv
);

  logic     released;
  logic     handed;
  pad_drv_t periph;

  assign released = resetout_n & ~glob_rst;
  assign handed   = released & en;
  assign periph   = drv_follow(pdo, poe);

  always_comb begin
    drv = DRV_OFF;
    case (GRP)
      GRP_ZL_LATE:  drv = released ? drv_const(1'b0) : DRV_OFF;
      GRP_ZH_LATE:  drv = released ? drv_const(1'b1) : DRV_OFF;
      GRP_ZX_LATE: begin
        if (!released)   drv = DRV_OFF;
        else if (handed) drv = periph;
        else             drv = drv_const(ALT);
      end
      GRP_Z:        drv = handed ? periph : DRV_OFF;
      GRP_LOW:      drv = handed ? periph : drv_const(1'b0);
      GRP_HIGH:     drv = handed ? periph : drv_const(1'b1);
      GRP_ZL_EARLY: drv = glob_rst ? DRV_OFF : drv_const(1'b0);
      GRP_ZH_EARLY: drv = glob_rst ? DRV_OFF : drv_const(1'b1);
      GRP_CLK:      drv = drv_const(ck_tgl);
      default:      drv = DRV_OFF;
    endcase
  end

endmodule

// File: rtl/pd_gate.sv
module pd_gate
  import pad_rst_pkg::*;
#(
  parameter bit PD_DEFAULT = 1'b0
)
(
  input  logic     pd_bit,
  input  logic     sel_bit,
  input  pad_drv_t drv_in,
  output pad_drv_t drv_out
);

  generate
    if (PD_DEFAULT) begin : g_gated
      logic powered;
      assign powered = ~pd_bit & sel_bit;
      assign drv_out = powered ? drv_in : DRV_OFF;
    end else begin : g_pass
      logic unused_ok;
      assign unused_ok = pd_bit ^ sel_bit;
      assign drv_out   = drv_in;
    end
  endgenerate

endmodule

// File: rtl/pad_reset_seq.sv
module pad_reset_seq
  import pad_rst_pkg::*;
#(
  parameter int                    NUM_PADS     = 11,
  parameter logic [NUM_PADS*4-1:0] PAD_GROUP    = 44'h45876543210,
  parameter logic [NUM_PADS-1:0]   GPIO_MASK    = 11'b010_0000_0000,
  parameter logic [NUM_PADS-1:0]   PD_MASK      = 11'b100_0000_0000,
  parameter int                    PAUSE_LEAD   = 4,
  parameter int                    PAUSE_CYCLES = 8
)
(
  input  logic                clk,
  input  logic                rst_por,
  input  logic                rst_ext,
  input  logic                rst_max,
  input  logic                resetout_n,
  input  logic [NUM_PADS-1:0] per_en,
  input  logic [NUM_PADS-1:0] per_do,
  input  logic [NUM_PADS-1:0] per_oe,
  input  logic [NUM_PADS-1:0] pd_reg,
  input  logic [NUM_PADS-1:0] mux_sel,
  output logic [NUM_PADS-1:0] pad_do,
  output logic [NUM_PADS-1:0] pad_oe
);

  logic glob_rst;
  logic ck_tgl;

  rst_phase_gen #(
    .PAUSE_LEAD   (PAUSE_LEAD),
    .PAUSE_CYCLES (PAUSE_CYCLES)
  ) phase_i (
    .clk      (clk),
    .rst_por  (rst_por),
    .rst_ext  (rst_ext),
    .rst_max  (rst_max),
    .glob_rst (glob_rst),
    .ck_tgl   (ck_tgl)
  );

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    localparam pad_grp_e RAW_GRP = pad_grp_e'(PAD_GROUP[4*i +: 4]);
    localparam pad_grp_e EFF_GRP = GPIO_MASK[i] ? GRP_Z : RAW_GRP;

    pad_drv_t lane_drv;
    pad_drv_t gated_drv;

    pad_lane #(
      .GRP (EFF_GRP),
      .ALT (i[0])
    ) lane_i (
      .glob_rst   (glob_rst),
      .resetout_n (resetout_n),
      .en         (per_en[i]),
      .pdo        (per_do[i]),
      .poe        (per_oe[i]),
      .ck_tgl     (ck_tgl),
      .drv        (lane_drv)
    );

    pd_gate #(
      .PD_DEFAULT (PD_MASK[i])
    ) pd_i (
      .pd_bit  (pd_reg[i]),
      .sel_bit (mux_sel[i]),
      .drv_in  (lane_drv),
      .drv_out (gated_drv)
    );

    assign pad_do[i] = gated_drv.dout;
    assign pad_oe[i] = gated_drv.oe;
  end

endmodule

// File: rtl/pad_reset_seq_chk.sv
module pad_reset_seq_chk
#(
  parameter int                    NUM_PADS     = 11,
  parameter logic [NUM_PADS*4-1:0] PAD_GROUP    = 44'h45876543210,
  parameter logic [NUM_PADS-1:0]   GPIO_MASK    = 11'b010_0000_0000,
  parameter logic [NUM_PADS-1:0]   PD_MASK      = 11'b100_0000_0000,
  parameter int                    PAUSE_LEAD   = 4,
  parameter int                    PAUSE_CYCLES = 8
)
(
  input logic                clk,
  input logic                rst_por,
  input logic                rst_ext,
  input logic                rst_max,
  input logic                resetout_n,
  input logic [NUM_PADS-1:0] per_en,
  input logic [NUM_PADS-1:0] pad_do,
  input logic [NUM_PADS-1:0] pad_oe
);

  localparam int LIM = PAUSE_LEAD + PAUSE_CYCLES + 1;
  localparam int CW  = $clog2(LIM + 1);

  logic          grst;
  logic          rel;
  logic [CW-1:0] edges;

  assign grst = rst_por | rst_ext | rst_max;
  assign rel  = resetout_n & ~grst;

  always_ff @(posedge clk or posedge grst) begin
    if (grst)                  edges <= '0;
    else if (edges < CW'(LIM)) edges <= edges + CW'(1);
  end

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_chk
    localparam logic [3:0] G = GPIO_MASK[i] ? 4'd3 : PAD_GROUP[4*i +: 4];
    localparam bit PD = PD_MASK[i];

    always @(negedge clk) begin
      if (grst && (G == 4'd0 || G == 4'd1 || G == 4'd2 || G == 4'd3 ||
                   G == 4'd6 || G == 4'd7))
        a_r1_zfirst_float: assert (pad_oe[i] == 1'b0);
      if (!rel && (G == 4'd0 || G == 4'd1))
        a_r2_late_float: assert (pad_oe[i] == 1'b0);
      if (!PD && !(rel && per_en[i]) && (G == 4'd4 || G == 4'd5))
        a_r5_default_level: assert (pad_oe[i] && pad_do[i] == (G == 4'd5));
      if (!PD && !grst && (G == 4'd6 || G == 4'd7))
        a_r6_early_drive: assert (pad_oe[i] && pad_do[i] == (G == 4'd7));
    end

    if (G == 4'd8 && !PD) begin : g_clk
      a_r8_pause_low: assert property (@(posedge clk) disable iff (grst)
        (edges > CW'(PAUSE_LEAD) && edges <= CW'(PAUSE_LEAD + PAUSE_CYCLES))
        |-> (pad_do[i] == 1'b0));
      a_r7_clk_toggles: assert property (@(posedge clk) disable iff (grst)
        ((edges >= CW'(2) && edges <= CW'(PAUSE_LEAD)) ||
         edges > CW'(PAUSE_LEAD + PAUSE_CYCLES))
        |-> (pad_do[i] != $past(pad_do[i])));
    end
  end

endmodule

bind pad_reset_seq pad_reset_seq_chk #(
  .NUM_PADS     (NUM_PADS),
  .PAD_GROUP    (PAD_GROUP),
  .GPIO_MASK    (GPIO_MASK),
  .PD_MASK      (PD_MASK),
  .PAUSE_LEAD   (PAUSE_LEAD),
  .PAUSE_CYCLES (PAUSE_CYCLES)
) chk_i (
  .clk        (clk),
  .rst_por    (rst_por),
  .rst_ext    (rst_ext),
  .rst_max    (rst_max),
  .resetout_n (resetout_n),
  .per_en     (per_en),
  .pad_do     (pad_do),
  .pad_oe     (pad_oe)
);

// File: tb/pad_reset_seq_tb_top.sv
module pad_reset_seq_tb_top;

  localparam int N     = 11;
  localparam int LEAD  = 4;
  localparam int PAUSE = 8;
  localparam logic [N*4-1:0] GRPS = 44'h45876543210;
  localparam logic [N-1:0]   GPIO = 11'b010_0000_0000;
  localparam logic [N-1:0]   PDM  = 11'b100_0000_0000;
  localparam int CLK_PAD = 8;

  logic         clk = 1'b0;
  logic         rst_por = 1'b1, rst_ext = 1'b0, rst_max = 1'b0;
  logic         resetout_n = 1'b0;
  logic [N-1:0] per_en = '0, per_do = '0, per_oe = '0, pd_reg = '1, mux_sel = '0;
  logic [N-1:0] pad_do, pad_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pad_reset_seq #(
    .NUM_PADS (N), .PAD_GROUP (GRPS), .GPIO_MASK (GPIO), .PD_MASK (PDM),
    .PAUSE_LEAD (LEAD), .PAUSE_CYCLES (PAUSE)
  ) dut_i (
    .clk (clk), .rst_por (rst_por), .rst_ext (rst_ext), .rst_max (rst_max),
    .resetout_n (resetout_n), .per_en (per_en), .per_do (per_do),
    .per_oe (per_oe), .pd_reg (pd_reg), .mux_sel (mux_sel),
    .pad_do (pad_do), .pad_oe (pad_oe)
  );

  task automatic check(input string req, input int pad, input string what,
                       input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s pad %0d %s: actual %b expected %b", req, pad, what, act, exp);
    end
  endtask

  function automatic string req_of(input int g, input int pad);
    if (PDM[pad]) return "R10";
    if (GPIO[pad]) return "R9";
    case (g)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6, 7: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_pads(input bit gr);
    for (int i = 0; i < N; i++) begin
      int   g;
      bit   rel, take, chk_do;
      logic e_oe, e_do;
      g      = GPIO[i] ? 3 : int'(GRPS[4*i +: 4]);
      rel    = resetout_n && !gr;
      take   = rel && per_en[i];
      chk_do = 1'b1;
      case (g)
        0, 1: begin e_oe = rel; e_do = rel && (g == 1); end
        2: begin
          if (!rel)      begin e_oe = 0; e_do = 0; end
          else if (take) begin e_oe = per_oe[i]; e_do = per_do[i] & per_oe[i]; end
          else           begin e_oe = 1; e_do = 0; chk_do = (i % 2 == 0); end
        end
        3: begin e_oe = take ? per_oe[i] : 1'b0; e_do = take ? per_do[i] & per_oe[i] : 1'b0; end
        4, 5: begin
          if (take) begin e_oe = per_oe[i]; e_do = per_do[i] & per_oe[i]; end
          else      begin e_oe = 1; e_do = (g == 5); end
        end
        6, 7: begin e_oe = !gr; e_do = !gr && (g == 7); end
        default: begin e_oe = 1; e_do = 0; chk_do = 1'b0; end
      endcase
      if (PDM[i] && !(!pd_reg[i] && mux_sel[i])) begin
        e_oe = 0; e_do = 0; chk_do = 1'b1;
      end
      if (gr && (g <= 3 || g == 6 || g == 7) && !PDM[i])
        check("R1", i, "oe in reset", pad_oe[i], 1'b0);
      else
        check(req_of(g, i), i, "oe", pad_oe[i], e_oe);
      if (chk_do) check(req_of(g, i), i, "do", pad_do[i], e_do);
    end
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic exp_ck;
    // reset state, power-on source held
    @(negedge clk); #5;
    check_pads(1'b1);
    check("R7", CLK_PAD, "clk held in reset", pad_do[CLK_PAD], 1'b0);
    check("R7", CLK_PAD, "clk oe in reset", pad_oe[CLK_PAD], 1'b1);

    // sweep: phases 0..2 one reset source each, 3 reset-out low, 4 released
    for (int ph = 0; ph < 5; ph++) begin
      for (int p = 0; p < 16; p++) begin
        @(negedge clk);
        rst_por    = (ph == 0);
        rst_ext    = (ph == 1);
        rst_max    = (ph == 2);
        resetout_n = (ph == 4);
        per_en     = p[0] ? '1 : '0;
        per_do     = p[1] ? 11'h555 : 11'h2AA;
        per_oe     = p[2] ? '1 : 11'h0F0;
        pd_reg     = p[3] ? '1 : '0;
        mux_sel    = p[1] ? '1 : '0;
        #5;
        check_pads(ph < 3);
        check("R7", CLK_PAD, "clk oe", pad_oe[CLK_PAD], 1'b1);
      end
    end

    // clock pause: reset, release at a falling edge, count rising edges
    @(negedge clk);
    rst_por = 1'b1; resetout_n = 1'b0;
    @(negedge clk); @(negedge clk);
    #5 check("R7", CLK_PAD, "clk low in reset", pad_do[CLK_PAD], 1'b0);
    @(negedge clk);
    rst_por = 1'b0;
    for (int n = 1; n <= LEAD + PAUSE + 8; n++) begin
      @(posedge clk); #5;
      if (n <= LEAD)              exp_ck = n[0];
      else if (n <= LEAD + PAUSE) exp_ck = 1'b0;
      else                        exp_ck = ((n - LEAD - PAUSE) % 2) == 1;
      check((n > LEAD && n <= LEAD + PAUSE) ? "R8" : "R7", CLK_PAD,
            "clk phase", pad_do[CLK_PAD], exp_ck);
      if (n == LEAD + PAUSE) resetout_n = 1'b1;
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule